// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of the transfer engine of a multi-channel DMA controller. Each channel has three ways to ask for service: a burst request line, a single-transfer request line and a software trigger pulse. Software sets up a channel with one configuration write. That write carries the number of transfers left, a priority bit, a 4-bit rate exponent and a single-request enable. The write also enables the channel, provided the count is not zero.

Whenever the arbiter is idle, it picks one pending channel and holds that grant for a whole interval. For a burst or triggered request, the interval is 2^R transfers, with R saturated at a ceiling. For a request that comes only on the single line, the interval is one transfer. The interval ends early when the channel's remaining count reaches zero. Each transfer is handed to the engine through a valid/ready pair. The channel number and a last-of-interval flag travel with each transfer. When a channel's count runs out, the arbiter raises a one-cycle done pulse and disables the channel.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `xfer_valid` is low, `ch_done` is all zero and every channel is disabled.
- R2: A granted burst request receives consecutive transfers on the same `xfer_ch`, 2^R of them, where R is the channel's rate exponent. After the final handshake `xfer_valid` is low for one cycle while the arbiter picks again. A new grant shows `xfer_valid` one cycle after the pending request is visible to an idle arbiter.
- R3: A rate exponent above 10 behaves as 10, so the interval is 1024 transfers.
- R4: If a channel has single requests enabled and only its single line is high, the channel receives exactly one transfer per grant. If the burst line is also high, the request is handled as a burst.
- R5: If single requests are disabled on a channel, a request on its single line alone never produces a transfer.
- R6: A software trigger pulse is held pending until its channel is granted. The pending trigger is served as a burst and is cleared when the grant is taken. A trigger that arrives while its channel is being served is kept for a later grant.
- R7: When the arbiter picks, a pending channel with priority bit 1 beats every channel with priority bit 0. Among channels of equal priority, the lowest channel number wins.
- R8: Each handshake lowers the granted channel's remaining count by one. The handshake that takes the count to zero ends the grant. On the next cycle, that channel's `ch_done` bit pulses high and the channel is disabled. Its requests are then ignored until software writes the channel again.
- R9: While `xfer_ready` is low, `xfer_valid` stays high and `xfer_ch` stays the same, and no count advances.
- R10: `xfer_last` is high exactly on the transfer that ends the current grant, whether the grant ends because its interval is used up or because the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_req | input | NCH | Burst request line per channel |
| single_req | input | NCH | Single-transfer request line per channel |
| sw_trig | input | NCH | Software trigger pulse per channel |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ch | input | IDX_W | Channel addressed by the write |
| cfg_cnt | input | CNT_W | Remaining transfer count to load |
| cfg_rpow | input | RP_W | Rate exponent R |
| cfg_hipri | input | 1 | Priority bit (1 = high) |
| cfg_sglen | input | 1 | Enable for single requests |
| xfer_valid | output | 1 | A transfer is offered to the engine |
| xfer_ready | input | 1 | The engine accepts the offered transfer |
| xfer_ch | output | IDX_W | Channel that owns the offered transfer |
| xfer_last | output | 1 | The offered transfer ends the grant |
| ch_done | output | NCH | One-cycle pulse when a channel's count is used up |

## Verification
The hardest case to reach is the saturated interval. It needs a channel whose count is above 1024, whose exponent is above the ceiling, and whose burst line stays high for more than a thousand handshakes. A directed phase sets that up with `xfer_ready` held high and measures the run length. A second hard case is a trigger that arrives while its own channel is being served. The stimulus pulses the trigger in the middle of a burst and then confirms that a second grant follows. The random phase mixes configuration writes, request patterns and stalls, and a cycle-level reference model predicts every output.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_MOVE = 1'b1
   } arb_st_e;

   // clamp a rate exponent to the ceiling
   function automatic int unsigned rate_clamp(input int unsigned rp, input int unsigned ceil_v);
      return (rp > ceil_v) ? ceil_v : rp;
   endfunction

endpackage

// File: rtl/dma_arb_chan.sv
module dma_arb_chan #(
   parameter int CNT_W = 16,
   parameter int RP_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CNT_W-1:0] cfg_cnt,
   input  logic [RP_W-1:0]  cfg_rpow,
   input  logic             cfg_hipri,
   input  logic             cfg_sglen,
   input  logic             burst_req,
   input  logic             single_req,
   input  logic             sw_trig,
   input  logic             grant_take,
   input  logic             xfer_dec,
   output logic             burst_elig,
   output logic             single_elig,
   output logic             hipri,
   output logic [RP_W-1:0]  rpow,
   output logic             cnt_one,
   output logic             done
);

   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sgl_q;
   logic             pend_q;

   assign cnt_one     = (cnt_q == CNT_W'(1));
   assign burst_elig  = en_q & (burst_req | pend_q);
   assign single_elig = en_q & sgl_q & single_req & ~burst_req & ~pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         cnt_q  <= '0;
         rpow   <= '0;
         hipri  <= 1'b0;
         sgl_q  <= 1'b0;
         pend_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         if (cfg_wr) begin
            en_q  <= |cfg_cnt;
            cnt_q <= cfg_cnt;
            rpow  <= cfg_rpow;
            hipri <= cfg_hipri;
            sgl_q <= cfg_sglen;
         end else if (xfer_dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_one) en_q <= 1'b0;
         end
         pend_q <= (pend_q & ~grant_take) | sw_trig;
         done   <= xfer_dec & cnt_one & ~cfg_wr;
      end
   end

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
   parameter int NCH   = 8,
   parameter int IDX_W = 3
) (
   input  logic [NCH-1:0]   req,
   input  logic [NCH-1:0]   hi,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   logic [NCH-1:0] hot;
   logic [NCH-1:0] pool;

   assign hot  = req & hi;
   assign pool = (|hot) ? hot : req;
   assign any  = |req;

   always_comb begin
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pool[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
   parameter int NCH    = 8,
   parameter int CNT_W  = 16,
   parameter int RP_W   = 4,
   parameter int RP_MAX = 10,
   localparam int IDX_W = $clog2(NCH),
   localparam int BUD_W = RP_MAX + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   burst_req,
   input  logic [NCH-1:0]   single_req,
   input  logic [NCH-1:0]   sw_trig,
   input  logic             cfg_wr,
   input  logic [IDX_W-1:0] cfg_ch,
   input  logic [CNT_W-1:0] cfg_cnt,
   input  logic [RP_W-1:0]  cfg_rpow,
   input  logic             cfg_hipri,
   input  logic             cfg_sglen,
   output logic             xfer_valid,
   input  logic             xfer_ready,
   output logic [IDX_W-1:0] xfer_ch,
   output logic             xfer_last,
   output logic [NCH-1:0]   ch_done
);
   import dma_arb_pkg::*;

   if (NCH < 2 || NCH != (1 << IDX_W)) begin : g_bad_nch
      $error("NCH must be a power of two and at least 2");
   end
   if (RP_MAX < 0 || RP_MAX >= (1 << RP_W) || RP_MAX > 16) begin : g_bad_rpmax
      $error("RP_MAX must fit the exponent field and stay at or below 16");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic [NCH-1:0]  b_el, s_el, hi_v, c_one, take, dec;
   logic [RP_W-1:0] rp_v [NCH];
   logic            any;
   logic [IDX_W-1:0] win;
   arb_st_e          st_q;
   logic [IDX_W-1:0] gch_q;
   logic [BUD_W-1:0] bud_q;
   logic             hs, start, ending;
   logic [RP_W-1:0]  rp_sat;
   logic [BUD_W-1:0] bud_load;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dma_arb_chan #(.CNT_W(CNT_W), .RP_W(RP_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_wr     (cfg_wr && (cfg_ch == IDX_W'(c))),
         .cfg_cnt    (cfg_cnt),
         .cfg_rpow   (cfg_rpow),
         .cfg_hipri  (cfg_hipri),
         .cfg_sglen  (cfg_sglen),
         .burst_req  (burst_req[c]),
         .single_req (single_req[c]),
         .sw_trig    (sw_trig[c]),
         .grant_take (take[c]),
         .xfer_dec   (dec[c]),
         .burst_elig (b_el[c]),
         .single_elig(s_el[c]),
         .hipri      (hi_v[c]),
         .rpow       (rp_v[c]),
         .cnt_one    (c_one[c]),
         .done       (ch_done[c])
      );
      assign take[c] = start && (win == IDX_W'(c));
      assign dec[c]  = hs && (gch_q == IDX_W'(c));
   end

   dma_arb_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
      .req (b_el | s_el),
      .hi  (hi_v),
      .any (any),
      .idx (win)
   );

   assign start    = (st_q == ARB_IDLE) && any;
   assign hs       = (st_q == ARB_MOVE) && xfer_ready;
   assign ending   = (bud_q == BUD_W'(1)) || c_one[gch_q];
   assign rp_sat   = RP_W'(rate_clamp(int'(rp_v[win]), RP_MAX));
   assign bud_load = b_el[win] ? (BUD_W'(1) << rp_sat) : BUD_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ARB_IDLE;
         gch_q <= '0;
         bud_q <= '0;
      end else begin
         case (st_q)
            ARB_IDLE: if (start) begin
               st_q  <= ARB_MOVE;
               gch_q <= win;
               bud_q <= bud_load;
            end
            default: if (hs) begin
               bud_q <= bud_q - BUD_W'(1);
               if (ending) st_q <= ARB_IDLE;
            end
         endcase
      end
   end

   assign xfer_valid = (st_q == ARB_MOVE);
   assign xfer_ch    = gch_q;
   assign xfer_last  = xfer_valid && ending;

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
   parameter int NCH    = 8,
   parameter int RP_MAX = 10,
   localparam int IDX_W = $clog2(NCH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xfer_valid,
   input logic             xfer_ready,
   input logic [IDX_W-1:0] xfer_ch,
   input logic             xfer_last,
   input logic [NCH-1:0]   ch_done
);

   localparam int CAP = 1 << RP_MAX;
   logic [RP_MAX+1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (xfer_valid && xfer_ready) begin
         AST_INTERVAL_CAP: assert (run_q < (RP_MAX+2)'(CAP)) else $error("interval too long"); // R3
         run_q <= xfer_last ? '0 : run_q + 1'b1;
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_ch)); // R9

   AST_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && xfer_ready && !xfer_last |=> xfer_valid && $stable(xfer_ch)); // R2

   AST_REARB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && xfer_ready && xfer_last |=> !xfer_valid); // R10

   AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_done)); // R8

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !(xfer_ready && xfer_last) |=> ch_done == '0); // R8

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH), .RP_MAX(RP_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_valid (xfer_valid),
   .xfer_ready (xfer_ready),
   .xfer_ch    (xfer_ch),
   .xfer_last  (xfer_last),
   .ch_done    (ch_done)
);

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;
   localparam int NCH = 8, CNT_W = 16, RP_W = 4, RP_MAX = 10, IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] burst_req = '0, single_req = '0, sw_trig = '0;
   logic cfg_wr = 1'b0;
   logic [IW-1:0] cfg_ch = '0;
   logic [CNT_W-1:0] cfg_cnt = '0;
   logic [RP_W-1:0] cfg_rpow = '0;
   logic cfg_hipri = 1'b0, cfg_sglen = 1'b0;
   logic xfer_valid, xfer_ready = 1'b1, xfer_last;
   logic [IW-1:0] xfer_ch;
   logic [NCH-1:0] ch_done;

   always #4 clk = ~clk;

   dma_req_arbiter uut (.*);

   int vectors = 0, fails = 0, cyc = 0;
   string tag = "R1";
   bit rdy_rand = 0;

   // reference model
   bit m_busy; int m_ch, m_bud;
   bit m_en[NCH], m_pend[NCH], m_hi[NCH], m_sg[NCH];
   int m_cnt[NCH], m_rp[NCH];
   logic [NCH-1:0] m_done;

   function automatic int budget_for(int rp);
      return 1 << ((rp > RP_MAX) ? RP_MAX : rp);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_ch = 0; m_bud = 0; m_done = '0;
         for (int i = 0; i < NCH; i++) begin
            m_en[i] = 0; m_pend[i] = 0; m_hi[i] = 0; m_sg[i] = 0; m_cnt[i] = 0; m_rp[i] = 0;
         end
      end else begin
         logic [NCH-1:0] nd, clr;
         nd = '0; clr = '0;
         if (m_busy) begin
            if (xfer_ready) begin
               bit fin;
               fin = (m_bud == 1) || (m_cnt[m_ch] == 1);
               if (m_cnt[m_ch] == 1) begin m_en[m_ch] = 0; nd[m_ch] = 1; end
               m_cnt[m_ch]--; m_bud--;
               if (fin) m_busy = 0;
            end
         end else begin
            int w; bit found, isb;
            found = 0; w = 0;
            for (int pass = 1; pass >= 0 && !found; pass--)
               for (int i = 0; i < NCH && !found; i++) begin
                  bit b, s;
                  b = m_en[i] && (burst_req[i] || m_pend[i]);
                  s = m_en[i] && m_sg[i] && single_req[i];
                  if ((b || s) && (m_hi[i] == pass[0])) begin found = 1; w = i; end
               end
            if (found) begin
               isb = burst_req[w] || m_pend[w];
               m_busy = 1; m_ch = w; m_bud = isb ? budget_for(m_rp[w]) : 1;
               clr[w] = 1;
            end
         end
         for (int i = 0; i < NCH; i++) m_pend[i] = (m_pend[i] && !clr[i]) || sw_trig[i];
         if (cfg_wr) begin
            m_en[cfg_ch] = (cfg_cnt != 0); m_cnt[cfg_ch] = cfg_cnt; m_rp[cfg_ch] = cfg_rpow;
            m_hi[cfg_ch] = cfg_hipri; m_sg[cfg_ch] = cfg_sglen;
            if (nd[cfg_ch]) nd[cfg_ch] = 0;
         end
         m_done = nd;
      end
   end

   task automatic check(string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) begin
         @(negedge clk);
         check("xfer_valid", int'(xfer_valid), int'(m_busy));
         if (m_busy) begin
            check("xfer_ch", int'(xfer_ch), m_ch);
            check("xfer_last", int'(xfer_last), int'((m_bud == 1) || (m_cnt[m_ch] == 1)));
         end
         check("ch_done", int'(ch_done), int'(m_done));
         sw_trig = '0; cfg_wr = 1'b0;
         xfer_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      end
   endtask

   task automatic cfg(int c, int n, int rp, bit hi, bit sg);
      cfg_wr = 1; cfg_ch = IW'(c); cfg_cnt = CNT_W'(n); cfg_rpow = RP_W'(rp);
      cfg_hipri = hi; cfg_sglen = sg;
      tick();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
         finish_run();
      end
   end

   initial begin
      int runlen, maxrun, dones;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("reset valid", int'(xfer_valid), 0);
      check("reset done", int'(ch_done), 0);
      rst_n = 1'b1;
      tick(2);

      // R2 / R10: burst interval of 2^2 with stall-free engine
      tag = "R2";
      cfg(3, 20, 2, 0, 0);
      burst_req[3] = 1; tick(12);
      tag = "R10"; tick(8);
      burst_req = '0; tick(6);

      // R9: same burst with random stalls
      tag = "R9"; rdy_rand = 1;
      cfg(3, 9, 1, 0, 0);
      burst_req[3] = 1; tick(40); burst_req = '0; rdy_rand = 0; tick(4);

      // R3: saturation at 1024
      tag = "R3";
      cfg(1, 1500, 15, 0, 0);
      burst_req[1] = 1; runlen = 0; maxrun = 0;
      repeat (1200) begin
         tick();
         if (xfer_valid && xfer_ready) begin
            runlen++;
            if (xfer_last) begin if (runlen > maxrun) maxrun = runlen; runlen = 0; end
         end
      end
      burst_req = '0;
      check("R3 longest interval", maxrun, 1024);
      tick(400);

      // R4: single only gives one transfer per grant; single+burst acts as burst
      tag = "R4";
      cfg(5, 30, 3, 0, 1);
      single_req[5] = 1; tick(12);
      burst_req[5] = 1; tick(20);
      burst_req = '0; single_req = '0; tick(4);

      // R5: single disabled is ignored
      tag = "R5";
      cfg(6, 10, 0, 0, 0);
      single_req[6] = 1; tick(20);
      check("R5 no transfer", int'(xfer_valid), 0);
      single_req = '0; tick(2);

      // R6: software trigger, including one arriving mid-service
      tag = "R6";
      cfg(2, 40, 2, 0, 0);
      sw_trig[2] = 1; tick(3);
      sw_trig[2] = 1; tick(12);
      check("R6 pending cleared", int'(xfer_valid), 0);

      // R7: priority ordering
      tag = "R7";
      cfg(4, 3, 0, 0, 0); cfg(6, 3, 0, 1, 0); cfg(0, 3, 0, 0, 0); cfg(7, 3, 0, 1, 0);
      burst_req = 8'b1101_0001; tick(30);
      burst_req = '0; tick(4);

      // R8: early end on count, done pulse, channel disabled afterwards
      tag = "R8";
      cfg(3, 3, 3, 0, 0);
      burst_req[3] = 1; dones = 0;
      repeat (20) begin tick(); if (ch_done[3]) dones++; end
      check("R8 done pulses", dones, 1);
      check("R8 disabled", int'(xfer_valid), 0);
      burst_req = '0; tick(2);

      // random mix
      tag = "RAND"; rdy_rand = 1;
      repeat (5000) begin
         if (($urandom % 10) == 0) begin
            int c;
            c = $urandom % NCH;
            if (!(m_busy && m_ch == c)) begin
               cfg_wr = 1; cfg_ch = IW'(c); cfg_cnt = CNT_W'($urandom % 40);
               cfg_rpow = RP_W'($urandom % 6); cfg_hipri = $urandom % 2; cfg_sglen = $urandom % 2;
            end
         end
         if (($urandom % 8) == 0) burst_req = NCH'($urandom) & NCH'($urandom);
         if (($urandom % 8) == 0) single_req = NCH'($urandom);
         if (($urandom % 16) == 0) sw_trig = NCH'(1 << ($urandom % NCH));
         tick();
      end
      finish_run();
   end
endmodule